// File: doc/BRIEF.md
# Read-Modify-Write Operation Unit

This block carries out a single read-modify-write step on one 32-bit word. When `start` is accepted, it captures four things: the target address, a mask word, a value word and a control word. The 4-bit method code sits in bits 11:8 of the control word. The block then reads the word at the target address over a simple request/acknowledge bus. It transforms the returned data as the method code selects and writes the result back to the same address.

The eleven legal methods cover the following:
- a masked merge;
- increment and decrement;
- one-bit shifts and one-bit rotates;
- bitwise inversion;
- XOR, OR and AND against the mask.

A sequencer that walks a descriptor list drives the unit. Each operation ends with a one-cycle `done` pulse. If the method is illegal or the bus reports an error, `fault` is raised and memory is left untouched.

Top module: `rmw_unit`

## Requirements
- R1: While reset is applied, and after its release until the first start, `done`, `fault` and `bus_req` are all low.
- R2: Method code 0 writes back (read AND NOT mask) OR value.
- R3: Method 1 writes read+1 and method 2 writes read-1. Both wrap modulo 2^32, so 0xFFFFFFFF+1 gives 0 and 0-1 gives 0xFFFFFFFF.
- R4: Method 3 writes the read word shifted right by one bit and method 4 writes it shifted left by one bit. In both cases the vacated bit is filled with zero.
- R5: Method 5 rotates the read word right by one bit, so bit 0 moves into bit 31. Method 6 rotates it left by one bit, so bit 31 moves into bit 0.
- R6: Method 7 writes the bitwise inverse of the read word. Methods 8, 9 and 10 write read XOR mask, read OR mask and read AND mask respectively.
- R7: The method is taken only from bits 11:8 of the control word. All other control bits have no effect on the result.
- R8: Method codes 11 to 15 make no bus access at all. `done` pulses in the cycle after the start is accepted, with `fault` high.
- R9: Every legal operation issues exactly one read and then exactly one write, both to the captured target address. The write is requested only after the read has been acknowledged. The request, direction and address stay stable until the acknowledgement.
- R10: `done` is high for exactly one cycle. For a successful operation it rises in the cycle right after the clock edge at which the write is acknowledged.
- R11: A bus error on the read or the write aborts the operation without any write taking effect. `done` pulses with `fault` high, and `fault` stays high until the next accepted start.
- R12: An accepted start with a legal method clears `fault`, so a successful operation ends with `fault` low.
- R13: `start` is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_word | input | 32 | Control word; bits 11:8 hold the method code |
| tgt_addr | input | 32 | Target word address |
| op_mask | input | 32 | Mask operand |
| op_value | input | 32 | Value operand |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write when high |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| done | output | 1 | One-cycle end-of-operation pulse |
| fault | output | 1 | Last operation was aborted or illegal |

## Verification
`done` is due one cycle after the clock edge that takes the write acknowledgement. For illegal methods it is due one cycle after the edge that accepts `start`. The bench's bus model records the cycle number at which it acknowledges each write, and the bench checks that `done` is first seen at that cycle plus one. `fault` and the written word are compared at that same sampling point, half a cycle away from the edge. `done` must be low again one cycle later. The bus model is run with several acknowledgement latencies, so the timing checks do not depend on a fixed number of cycles between start and completion.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int METH_W = 4;

  localparam logic [METH_W-1:0] M_MERGE = 4'd0;
  localparam logic [METH_W-1:0] M_INC   = 4'd1;
  localparam logic [METH_W-1:0] M_DEC   = 4'd2;
  localparam logic [METH_W-1:0] M_SHR   = 4'd3;
  localparam logic [METH_W-1:0] M_SHL   = 4'd4;
  localparam logic [METH_W-1:0] M_ROR   = 4'd5;
  localparam logic [METH_W-1:0] M_ROL   = 4'd6;
  localparam logic [METH_W-1:0] M_INV   = 4'd7;
  localparam logic [METH_W-1:0] M_XOR   = 4'd8;
  localparam logic [METH_W-1:0] M_OR    = 4'd9;
  localparam logic [METH_W-1:0] M_AND   = 4'd10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_END  = 2'd3
  } rmw_state_e;

  function automatic logic meth_legal(input logic [METH_W-1:0] m);
    return (m <= M_AND);
  endfunction
endpackage

// File: rtl/rmw_rst_sync.sv
module rmw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rmw_xform.sv
module rmw_xform
  import rmw_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [METH_W-1:0] meth,
  input  logic [W-1:0]      rd,
  input  logic [W-1:0]      mask,
  input  logic [W-1:0]      val,
  output logic [W-1:0]      res
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (meth)
      M_MERGE: res = (rd & ~mask) | val;
      M_INC:   res = rd + ONE;
      M_DEC:   res = rd - ONE;
      M_SHR:   res = {1'b0, rd[W-1:1]};
      M_SHL:   res = {rd[W-2:0], 1'b0};
      M_ROR:   res = {rd[0], rd[W-1:1]};
      M_ROL:   res = {rd[W-2:0], rd[W-1]};
      M_INV:   res = ~rd;
      M_XOR:   res = rd ^ mask;
      M_OR:    res = rd | mask;
      M_AND:   res = rd & mask;
      default: res = rd;
    endcase
  end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [METH_W-1:0] meth_in,
  input  logic [AW-1:0]     addr_in,
  input  logic [W-1:0]      mask_in,
  input  logic [W-1:0]      val_in,
  input  logic              ack,
  input  logic              berr,
  input  logic [W-1:0]      rdata,
  output logic              req,
  output logic              we,
  output logic [AW-1:0]     addr,
  output logic [METH_W-1:0] meth,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      val,
  output logic [W-1:0]      rd_word,
  output logic              done,
  output logic              fault
);
  rmw_state_e state_q, state_d;
  logic       fault_q, fault_d;
  logic       cap_en, data_en, fault_en;
  logic [AW-1:0]     addr_q;
  logic [METH_W-1:0] meth_q;
  logic [W-1:0]      mask_q, val_q, data_q;

  always_comb begin
    state_d  = state_q;
    fault_d  = fault_q;
    fault_en = 1'b0;
    cap_en   = 1'b0;
    data_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en   = 1'b1;
          fault_en = 1'b1;
          if (meth_legal(meth_in)) begin
            state_d = ST_RD;
            fault_d = 1'b0;
          end else begin
            state_d = ST_END;
            fault_d = 1'b1;
          end
        end
      end
      ST_RD: begin
        if (berr) begin
          state_d  = ST_END;
          fault_d  = 1'b1;
          fault_en = 1'b1;
        end else if (ack) begin
          data_en = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (berr) begin
          state_d  = ST_END;
          fault_d  = 1'b1;
          fault_en = 1'b1;
        end else if (ack) begin
          state_d = ST_END;
        end
      end
      ST_END: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fault_en) fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      meth_q <= '0;
      mask_q <= '0;
      val_q  <= '0;
    end else if (cap_en) begin
      addr_q <= addr_in;
      meth_q <= meth_in;
      mask_q <= mask_in;
      val_q  <= val_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= rdata;
    end
  end

  assign req     = (state_q == ST_RD) || (state_q == ST_WR);
  assign we      = (state_q == ST_WR);
  assign done    = (state_q == ST_END);
  assign fault   = fault_q;
  assign addr    = addr_q;
  assign meth    = meth_q;
  assign mask    = mask_q;
  assign val     = val_q;
  assign rd_word = data_q;
endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int W          = 32,
  parameter int AW         = 32,
  parameter int OPW        = 32,
  parameter int METHOD_LSB = 8,
  parameter int SYNC_STG   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op_word,
  input  logic [AW-1:0]  tgt_addr,
  input  logic [W-1:0]   op_mask,
  input  logic [W-1:0]   op_value,
  output logic           bus_req,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [W-1:0]   bus_wdata,
  input  logic [W-1:0]   bus_rdata,
  input  logic           bus_ack,
  input  logic           bus_err,
  output logic           done,
  output logic           fault
);
  localparam int METHOD_MSB = METHOD_LSB + METH_W - 1;

  logic              rst_n_int;
  logic [METH_W-1:0] meth_dec, meth_cur;
  logic [W-1:0]      mask_cur, val_cur, rd_cur;
  logic              unused_op_bits;

  assign meth_dec       = op_word[METHOD_MSB:METHOD_LSB];
  assign unused_op_bits = ^op_word;

  rmw_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rmw_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start   (start),
    .meth_in (meth_dec),
    .addr_in (tgt_addr),
    .mask_in (op_mask),
    .val_in  (op_value),
    .ack     (bus_ack),
    .berr    (bus_err),
    .rdata   (bus_rdata),
    .req     (bus_req),
    .we      (bus_we),
    .addr    (bus_addr),
    .meth    (meth_cur),
    .mask    (mask_cur),
    .val     (val_cur),
    .rd_word (rd_cur),
    .done    (done),
    .fault   (fault)
  );

  rmw_xform #(.W(W)) u_xform (
    .meth (meth_cur),
    .rd   (rd_cur),
    .mask (mask_cur),
    .val  (val_cur),
    .res  (bus_wdata)
  );
endmodule

// File: rtl/rmw_unit_chk.sv
module rmw_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack,
  input logic          bus_err,
  input logic          done,
  input logic          fault
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err |=> bus_req && $stable(bus_we) && $stable(bus_addr)); // R9
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_we); // R9
  AST_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> $past(bus_req) && $stable(bus_addr)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req); // R10
  AST_FAULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> done); // R11
endmodule

bind rmw_unit rmw_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_rmw_unit.sv
`timescale 1ns/1ps
module tb_rmw_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] op_word, tgt_addr, op_mask, op_value;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ack, bus_err, done, fault;

  always #2 clk = ~clk;

  rmw_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
    .tgt_addr(tgt_addr), .op_mask(op_mask), .op_value(op_value),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .done(done), .fault(fault)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [31:0] mem_word;
  logic [31:0] exp_addr;
  int  lat, rd_cnt, wr_cnt, wr_ack_cyc, order_bad, addr_bad;
  bit  inj_rd, inj_wr, rd_seen;
  bit  saw_done;
  int  done_cyc;
  logic after_done;

  // method, initial word, mask, value, expected word, expected fault
  localparam int NV = 15;
  localparam logic [132:0] VECS [NV] = '{
    {4'd0,  32'hA5A5F00F, 32'hFF00FF00, 32'h00120034, 32'h00B7003F, 1'b0},
    {4'd1,  32'h000000FF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000100, 1'b0},
    {4'd1,  32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0},
    {4'd2,  32'h00001000, 32'hFFFFFFFF, 32'h12345678, 32'h00000FFF, 1'b0},
    {4'd2,  32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b0},
    {4'd3,  32'h80000003, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h40000001, 1'b0},
    {4'd4,  32'hC0000001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000002, 1'b0},
    {4'd5,  32'h00000003, 32'h00000000, 32'h00000000, 32'h80000001, 1'b0},
    {4'd6,  32'h80000002, 32'h00000000, 32'h00000000, 32'h00000005, 1'b0},
    {4'd7,  32'h0F0F1234, 32'hFFFFFFFF, 32'h00000000, 32'hF0F0EDCB, 1'b0},
    {4'd8,  32'h12345678, 32'hFFFF0000, 32'h00000000, 32'hEDCB5678, 1'b0},
    {4'd9,  32'h12340000, 32'h0000ABCD, 32'h00000000, 32'h1234ABCD, 1'b0},
    {4'd10, 32'h12345678, 32'h0F0F0F0F, 32'hFFFFFFFF, 32'h02040608, 1'b0},
    {4'd11, 32'h55AA55AA, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h55AA55AA, 1'b1},
    {4'd15, 32'h55AA55AA, 32'h00000000, 32'h00000000, 32'h55AA55AA, 1'b1}
  };

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7, 4'd8, 4'd9, 4'd10: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial forever @(posedge clk) cyc++;

  // bus responder
  initial begin
    int wcnt;
    wcnt = 0;
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (bus_ack || bus_err) begin
        bus_ack = 1'b0; bus_err = 1'b0; wcnt = 0;
      end else if (bus_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          if (bus_addr !== exp_addr) addr_bad++;
          if (!bus_we) begin
            rd_cnt++; rd_seen = 1;
            if (inj_rd) bus_err = 1'b1;
            else begin bus_rdata = mem_word; bus_ack = 1'b1; end
          end else begin
            if (!rd_seen) order_bad++;
            wr_cnt++;
            if (inj_wr) bus_err = 1'b1;
            else begin mem_word = bus_wdata; bus_ack = 1'b1; wr_ack_cyc = cyc; end
          end
        end
      end
    end
  end

  task automatic prep(input logic [31:0] addr, input logic [31:0] init, input int l, input bit ir, input bit iw);
    lat = l; inj_rd = ir; inj_wr = iw; exp_addr = addr; mem_word = init;
    rd_cnt = 0; wr_cnt = 0; rd_seen = 0; wr_ack_cyc = -100;
    order_bad = 0; addr_bad = 0;
  endtask

  task automatic wait_done();
    saw_done = 0; done_cyc = -1;
    for (int i = 0; i < 80 && !saw_done; i++) begin
      if (done) begin saw_done = 1; done_cyc = cyc; end
      else @(negedge clk);
    end
    @(negedge clk);
    after_done = done;
  endtask

  task automatic do_op(input logic [31:0] opw, input logic [31:0] addr, input logic [31:0] mask,
                       input logic [31:0] val, input logic [31:0] init, input int l,
                       input bit ir, input bit iw);
    prep(addr, init, l, ir, iw);
    @(negedge clk);
    op_word = opw; tgt_addr = addr; op_mask = mask; op_value = val; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      report();
    end
  end

  initial begin
    logic [132:0] v;
    logic [3:0]   m;
    logic [31:0]  opw;
    rst_n = 1'b0; start = 1'b0;
    op_word = '0; tgt_addr = '0; op_mask = '0; op_value = '0;
    prep(32'h0, 32'h0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R1", "done in reset", {31'b0, done}, 32'd0);
    chk("R1", "req in reset", {31'b0, bus_req}, 32'd0);
    chk("R1", "fault in reset", {31'b0, fault}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done after reset", {31'b0, done}, 32'd0);
    chk("R1", "req after reset", {31'b0, bus_req}, 32'd0);
    chk("R1", "fault after reset", {31'b0, fault}, 32'd0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      m = v[132:129];
      // R7: bits outside 11:8 carry a varying junk pattern
      opw = ((32'hA5A5A5A5 ^ (32'h01010101 * k)) & ~32'h00000F00) | ({28'b0, m} << 8);
      do_op(opw, 32'h4000_0000 + 32'(k * 4), v[96:65], v[64:33], v[128:97], k % 3, 0, 0);
      chk(tag_of(m), "R7 written word", mem_word, v[32:1]);
      chk(tag_of(m), "fault", {31'b0, fault}, {31'b0, v[0]});
      chk("R10", "done seen", {31'b0, saw_done}, 32'd1);
      chk("R10", "done width", {31'b0, after_done}, 32'd0);
      if (v[0]) begin
        chk("R8", "bus accesses", 32'(rd_cnt + wr_cnt), 32'd0);
      end else begin
        chk("R9", "reads", 32'(rd_cnt), 32'd1);
        chk("R9", "writes", 32'(wr_cnt), 32'd1);
        chk("R9", "order/addr", 32'(order_bad + addr_bad), 32'd0);
        chk("R10", "done timing", 32'(done_cyc), 32'(wr_ack_cyc + 1));
      end
    end

    // R11: read error
    do_op(32'h0000_0100, 32'h2000_0010, 32'h0, 32'h0, 32'h0000_1234, 1, 1, 0);
    chk("R11", "read err word", mem_word, 32'h0000_1234);
    chk("R11", "read err fault", {31'b0, fault}, 32'd1);
    chk("R11", "read err writes", 32'(wr_cnt), 32'd0);
    chk("R11", "read err done", {31'b0, saw_done}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R11", "fault held", {31'b0, fault}, 32'd1);

    // R12: next legal op clears fault
    do_op(32'h0000_0200, 32'h2000_0014, 32'h0, 32'h0, 32'h0000_0010, 2, 0, 0);
    chk("R12", "fault cleared", {31'b0, fault}, 32'd0);
    chk("R12", "word", mem_word, 32'h0000_000F);

    // R11: write error
    do_op(32'h0000_0700, 32'h2000_0018, 32'h0, 32'h0, 32'hCAFE_0000, 0, 0, 1);
    chk("R11", "write err word", mem_word, 32'hCAFE_0000);
    chk("R11", "write err fault", {31'b0, fault}, 32'd1);
    chk("R11", "write err writes", 32'(wr_cnt), 32'd1);
    chk("R11", "write err done", {31'b0, saw_done}, 32'd1);

    // R13: start during a busy operation
    prep(32'h3000_0000, 32'h0000_0041, 3, 0, 0);
    @(negedge clk);
    op_word = 32'h0000_0100; tgt_addr = 32'h3000_0000; op_mask = '0; op_value = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (8) @(negedge clk);
    chk("R13", "reads", 32'(rd_cnt), 32'd1);
    chk("R13", "writes", 32'(wr_cnt), 32'd1);
    chk("R13", "word", mem_word, 32'h0000_0042);
    chk("R13", "idle bus", {31'b0, bus_req}, 32'd0);

    report();
  end
endmodule